// File: doc/BRIEF.md
# Register-programmed SPI master

This block is a serial peripheral interface master that software drives through a small register port. Three write addresses hold the clock divider, a control word and a transmit word. Two read addresses return the received word and a status word. Writing the transmit word starts a transfer. The transfer uses the control word that was written most recently. That word stays in place, so a driver only rewrites it when the slave mask, the bit count or the edge choice changes.

During a transfer the core drives the serial clock, the transmit line and a group of active-low slave selects, and samples the receive line. It sends a left-justified word MSB first and shifts the received bits in from the LSB end. A one-cycle `done` pulse marks the end of the transfer.

The transfer is sequenced by a state machine with four states:
- **IDLE**: waiting for a transmit-word write.
- **LEAD**: selects are asserted and SCLK is low for half a period.
- **SHIFT**: SCLK toggles once per half period until all 2·N edges have been made.
- **TRAIL**: selects stay asserted for half a period after the last edge.

The transitions are:
- IDLE→LEAD on an accepted start.
- LEAD→SHIFT on the first half-period tick, which is also the first rising edge.
- SHIFT→TRAIL on the tick that makes edge 2·N.
- TRAIL→IDLE on the next tick, which also releases the selects and pulses `done`.

Top module: `spim_core`

## Requirements
- R1: After reset, all `ss_n` bits are 1, `sclk`, `mosi` and `done` are 0, and both read addresses return 0.
- R2: Writes go to address 0 (divider, bits [DIV_W-1:0], reset value 4), address 1 (control word) and address 2 (transmit word, starts a transfer). The control word persists, so several transfers can run from a single control write.
- R3: SCLK idles low. Each SCLK half period lasts divider+1 clock cycles, so the full period is 2·(divider+1) cycles.
- R4: Control bits [29:24] give the bit count N. A value of 0, or any value above 32, means 32 bits. Values 1 to 32 mean that many bits.
- R5: MOSI carries transmit bits 31, 30, … down to 32−N, in that order. With control bit 31 = 1, MOSI changes on each rising SCLK edge. With bit 31 = 0, the first bit is present before the first rising edge and later bits change on falling edges.
- R6: With control bit 30 = 1, MISO is sampled on falling SCLK edges. With bit 30 = 0, it is sampled on rising edges.
- R7: Read address 0 returns the N received bits right-justified, first-received bit at bit N−1, with upper bits 0.
- R8: During a transfer, `ss_n` equals the inverse of control bits [SS_W-1:0]. Selects assert half a period before the first edge and release half a period after the last edge, in the same cycle as a one-cycle `done` pulse.
- R9: Read address 1 is status: bit 31 = busy (set from the start until `done`), bit 0 = overrun, and other bits 0.
- R10: A transmit-word write while busy is ignored and sets the sticky overrun flag. The ongoing transfer is unchanged.
- R11: A control write during a transfer does not affect that transfer. It takes effect from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address (0 divider, 1 control, 2 transmit) |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address (0 received word, 1 status) |
| reg_rdata | output | 32 | Read data, combinational from `reg_raddr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | SS_W | Active-low slave selects |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Three events can coincide on a single SCLK edge: a MOSI launch, a MISO capture and a half-period tick. They coincide when the launch edge and the capture edge are set to the same polarity. They coincide most densely with a divider of 0, where every clock cycle is an edge. The bench sweeps all four edge combinations over dividers 0, 1 and 4 and many bit counts. A slave model reads MOSI on the edge opposite the launch edge and drives MISO on the edge opposite the capture edge. The result in both directions is compared with the shifted transmit word and the slave's pattern. A second collision, a transmit-word write arriving while the machine is mid-transfer, is provoked directly. It is judged by the unchanged serial output and by the status bits.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } spim_state_e;

    localparam logic [1:0] WA_DIV  = 2'd0;
    localparam logic [1:0] WA_CTRL = 2'd1;
    localparam logic [1:0] WA_DATA = 2'd2;
    localparam logic [1:0] RA_RX   = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;

    localparam int WORD_W   = 32;
    localparam int CNTF_W   = 6;
    localparam int MASK_W   = 24;
    localparam int MAX_BITS = 32;

    // control word laid out MSB first: launch edge, capture edge, count, mask
    typedef struct packed {
        logic                launch_rise;
        logic                cap_fall;
        logic [CNTF_W-1:0]   count;
        logic [MASK_W-1:0]   mask;
    } spim_ctrl_t;

endpackage

// File: rtl/spim_regs.sv
`timescale 1ns/1ps
module spim_regs
    import spim_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              busy,
    input  logic [WORD_W-1:0] rx_word,
    output logic [DIV_W-1:0]  div_q,
    output spim_ctrl_t        ctrl_q,
    output logic              start,
    output logic              overrun
);

    logic data_wr;

    assign data_wr = wr_en && (wr_addr == WA_DATA);
    assign start   = data_wr && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= DIV_W'(DIV_RESET);
            ctrl_q  <= '0;
            overrun <= 1'b0;
        end else begin
            if (wr_en && (wr_addr == WA_DIV)) begin
                div_q <= wr_data[DIV_W-1:0];
            end
            if (wr_en && (wr_addr == WA_CTRL)) begin
                ctrl_q <= spim_ctrl_t'(wr_data);
            end
            if (data_wr && busy) begin
                overrun <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_RX:   rd_data = rx_word;
            RA_STAT: rd_data = {busy, {(WORD_W-2){1'b0}}, overrun};
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/spim_tick.sv
`timescale 1ns/1ps
module spim_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] reload_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
        end else if (load) begin
            cnt_q    <= div;
            reload_q <= div;
        end else if (run) begin
            if (cnt_q == '0) begin
                cnt_q <= reload_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/spim_fsm.sv
`timescale 1ns/1ps
module spim_fsm
    import spim_pkg::*;
#(
    parameter int SS_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  spim_ctrl_t      ctrl_in,
    input  logic            tick,
    output spim_state_e     state,
    output logic            sclk,
    output logic [SS_W-1:0] ss_n,
    output logic            done,
    output logic            launch,
    output logic            capture
);

    localparam int EDGE_W = CNTF_W + 1;

    spim_state_e       state_nx;
    spim_ctrl_t        cfg_q;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-1:0] edge_nx;
    logic [EDGE_W-1:0] edge_total;
    logic [CNTF_W-1:0] nbits;
    logic              edge_fire;
    logic              edge_rise;
    logic              edge_fall;
    logic              last_edge;

    assign nbits      = ((cfg_q.count == '0) || (cfg_q.count > CNTF_W'(MAX_BITS)))
                        ? CNTF_W'(MAX_BITS) : cfg_q.count;
    assign edge_total = {nbits, 1'b0};
    assign edge_nx    = edge_cnt + 1'b1;
    assign last_edge  = (edge_nx == edge_total);

    assign edge_fire = tick && ((state == ST_LEAD) || (state == ST_SHIFT));
    assign edge_rise = edge_fire && !sclk;
    assign edge_fall = edge_fire && sclk;

    // the first bit of a falling-edge launch is preloaded at start, so the
    // final falling edge launches nothing
    assign launch  = cfg_q.launch_rise ? edge_rise : (edge_fall && !last_edge);
    assign capture = cfg_q.cap_fall ? edge_fall : edge_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)                  state_nx = ST_LEAD;
            ST_LEAD:  if (tick)                   state_nx = ST_SHIFT;
            ST_SHIFT: if (tick && last_edge)      state_nx = ST_TRAIL;
            ST_TRAIL: if (tick)                   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            edge_cnt <= '0;
            sclk     <= 1'b0;
            ss_n     <= '1;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q    <= ctrl_in;
                        edge_cnt <= '0;
                        ss_n     <= ~ctrl_in.mask[SS_W-1:0];
                    end
                end
                ST_LEAD, ST_SHIFT: begin
                    if (edge_fire) begin
                        sclk     <= ~sclk;
                        edge_cnt <= edge_nx;
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        ss_n <= '1;
                        done <= 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/spim_shift.sv
`timescale 1ns/1ps
module spim_shift
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              preload,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              launch,
    input  logic              capture,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);

    logic [WORD_W-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            mosi    <= 1'b0;
            rx_word <= '0;
        end else if (start) begin
            rx_word <= '0;
            if (preload) begin
                mosi <= tx_word[WORD_W-1];
                tx_q <= {tx_word[WORD_W-2:0], 1'b0};
            end else begin
                tx_q <= tx_word;
            end
        end else begin
            if (launch) begin
                mosi <= tx_q[WORD_W-1];
                tx_q <= {tx_q[WORD_W-2:0], 1'b0};
            end
            if (capture) begin
                rx_word <= {rx_word[WORD_W-2:0], miso};
            end
        end
    end

endmodule

// File: rtl/spim_core.sv
`timescale 1ns/1ps
module spim_core
    import spim_pkg::*;
#(
    parameter int SS_W      = 24,
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_waddr,
    input  logic [31:0]      reg_wdata,
    input  logic [1:0]       reg_raddr,
    output logic [31:0]      reg_rdata,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic [SS_W-1:0]  ss_n,
    output logic             done
);

    spim_state_e       state;
    spim_ctrl_t        ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [WORD_W-1:0] rx_word;
    logic              busy;
    logic              start;
    logic              overrun;
    logic              tick;
    logic              launch;
    logic              capture;

    assign busy = (state != ST_IDLE);

    spim_regs #(
        .DIV_W     (DIV_W),
        .DIV_RESET (DIV_RESET)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_addr (reg_waddr),
        .wr_data (reg_wdata),
        .rd_addr (reg_raddr),
        .rd_data (reg_rdata),
        .busy    (busy),
        .rx_word (rx_word),
        .div_q   (div_q),
        .ctrl_q  (ctrl_q),
        .start   (start),
        .overrun (overrun)
    );

    spim_tick #(
        .DIV_W (DIV_W)
    ) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .run   (busy),
        .div   (div_q),
        .tick  (tick)
    );

    spim_fsm #(
        .SS_W (SS_W)
    ) i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ctrl_in (ctrl_q),
        .tick    (tick),
        .state   (state),
        .sclk    (sclk),
        .ss_n    (ss_n),
        .done    (done),
        .launch  (launch),
        .capture (capture)
    );

    spim_shift i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .preload (!ctrl_q.launch_rise),
        .tx_word (reg_wdata),
        .launch  (launch),
        .capture (capture),
        .miso    (miso),
        .mosi    (mosi),
        .rx_word (rx_word)
    );

endmodule

// File: rtl/spim_core_chk.sv
`timescale 1ns/1ps
module spim_core_chk #(
    parameter int SS_W = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [1:0]      reg_waddr,
    input logic            sclk,
    input logic            mosi,
    input logic [SS_W-1:0] ss_n,
    input logic            done,
    input logic            busy,
    input logic            overrun
);

    // R1 / R3: no clock and no select outside a transfer
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((&ss_n) && !sclk));

    a_r3_rise_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> busy);

    // R8: done is a single-cycle pulse coinciding with select release
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && (&ss_n)));

    // R5: MOSI moves only with an SCLK edge or at the start of a transfer
    a_r5_mosi_edges: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> ($rose(sclk) || $fell(sclk) || $past(!busy)));

    // R10: transmit write while busy flags overrun, which then stays set
    a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_waddr == 2'd2) && busy) |=> overrun);

    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind spim_core spim_core_chk #(.SS_W(SS_W)) i_spim_core_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_waddr (reg_waddr),
    .sclk      (sclk),
    .mosi      (mosi),
    .ss_n      (ss_n),
    .done      (done),
    .busy      (busy),
    .overrun   (overrun)
);

// File: tb/test_spim_core.sv
`timescale 1ns/1ps
module test_spim_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        sclk;
    logic        mosi;
    logic        miso = 1'b0;
    logic [23:0] ss_n;
    logic        done;

    spim_core i_spim_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso),
        .ss_n      (ss_n),
        .done      (done)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always @(negedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    logic        tb_lr = 1'b0;
    logic        tb_cf = 1'b0;
    int          tb_n = 8;
    int          tb_div = 4;
    logic [23:0] tb_mask = '0;
    logic [31:0] tb_pat = '0;
    logic [31:0] tb_data = '0;
    logic [31:0] s_rx = '0;
    logic [23:0] ss_seen = '1;
    int          s_idx = 0;
    int          t_ss_fall = 0, t_prev_rise = 0, t_last_edge = 0;
    int          lead_meas = 0, period_meas = 0, trail_meas = 0;
    bit          first_rise = 1'b0;
    wire         ss_all = &ss_n;

    always @(negedge ss_all) begin
        s_idx      = tb_n - 1;
        s_rx       = '0;
        ss_seen    = ss_n;
        t_ss_fall  = cyc;
        first_rise = 1'b1;
        if (!tb_cf) miso = tb_pat[s_idx];
    end

    always @(posedge sclk) begin
        if (first_rise) lead_meas = cyc - t_ss_fall;
        else            period_meas = cyc - t_prev_rise;
        first_rise  = 1'b0;
        t_prev_rise = cyc;
        t_last_edge = cyc;
        if (!tb_lr) s_rx = {s_rx[30:0], mosi};
        if (tb_cf && s_idx >= 0) begin
            miso = tb_pat[s_idx];
            s_idx--;
        end
    end

    always @(negedge sclk) begin
        t_last_edge = cyc;
        if (tb_lr) s_rx = {s_rx[30:0], mosi};
        if (!tb_cf) begin
            s_idx--;
            if (s_idx >= 0) miso = tb_pat[s_idx];
        end
    end

    always @(posedge ss_all) trail_meas = cyc - t_last_edge;

    // ---------------- bus tasks ----------------
    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input logic lr, input logic cf,
                                              input logic [5:0] fld, input logic [23:0] m);
        return {lr, cf, fld, m};
    endfunction

    // write divider and control, remember the expected configuration
    task automatic set_cfg(input int dv, input logic lr, input logic cf,
                           input int n, input logic [5:0] fld, input logic [23:0] m);
        bus_wr(2'd0, dv);
        bus_wr(2'd1, ctrl_word(lr, cf, fld, m));
        tb_div = dv; tb_lr = lr; tb_cf = cf; tb_n = n; tb_mask = m;
    endtask

    task automatic launch_x(input logic [31:0] d, input logic [31:0] p);
        tb_data = d; tb_pat = p;
        bus_wr(2'd2, d);
    endtask

    task automatic finish_x(input bit timing);
        logic [31:0] rd, exp_rx, exp_tx, nmask;
        while (!done) @(negedge clk);
        nmask  = (tb_n == 32) ? 32'hFFFF_FFFF : ((32'd1 << tb_n) - 1);
        exp_rx = tb_pat & nmask;
        exp_tx = tb_data >> (32 - tb_n);
        bus_rd(2'd0, rd);
        chk(rd == exp_rx, "R6 R7 R4", "received word", rd, exp_rx);
        chk((s_rx & nmask) == exp_tx, "R5 R4", "mosi bits", s_rx & nmask, exp_tx);
        chk(ss_seen == ~tb_mask, "R8", "select pattern", {8'h0, ss_seen}, {8'h0, ~tb_mask});
        if (timing) begin
            chk(lead_meas == tb_div + 1, "R8", "lead cycles", lead_meas, tb_div + 1);
            chk(trail_meas == tb_div + 1, "R8", "trail cycles", trail_meas, tb_div + 1);
            if (tb_n > 1)
                chk(period_meas == 2 * (tb_div + 1), "R3", "sclk period", period_meas, 2 * (tb_div + 1));
        end
        @(negedge clk);
        chk(done == 1'b0, "R8", "done width", done, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        logic [31:0] rd;
        int          k;
        int          dvs[3];
        int          ns[8];
        dvs = '{0, 1, 4};
        ns  = '{1, 2, 3, 8, 13, 24, 31, 32};
        k   = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ss_n == '1, "R1", "ss_n reset", {8'h0, ss_n}, 32'h00FF_FFFF);
        chk(sclk == 1'b0, "R1", "sclk reset", sclk, 0);
        chk(mosi == 1'b0, "R1", "mosi reset", mosi, 0);
        chk(done == 1'b0, "R1", "done reset", done, 0);
        bus_rd(2'd0, rd);
        chk(rd == 0, "R1", "rx reset", rd, 0);
        bus_rd(2'd1, rd);
        chk(rd == 0, "R1", "status reset", rd, 0);

        // R3 default divider of 4: control only, no divider write
        bus_wr(2'd1, ctrl_word(1'b0, 1'b0, 6'd8, 24'h000003));
        tb_div = 4; tb_lr = 0; tb_cf = 0; tb_n = 8; tb_mask = 24'h000003;
        launch_x(32'hB400_0000, 32'h0000_005A);
        finish_x(1'b1);

        // sweep: divider x launch edge x capture edge x bit count
        foreach (dvs[i]) begin
            for (int lr = 0; lr < 2; lr++) begin
                for (int cf = 0; cf < 2; cf++) begin
                    foreach (ns[j]) begin
                        logic [31:0] d, p;
                        logic [23:0] m;
                        k++;
                        d = 32'h9E37_79B9 * k;
                        p = {d[12:0], d[31:13]} ^ 32'h6D2B_79F5;
                        m = (24'h1 << (k % 24)) | ((k % 3 == 0) ? 24'h800000 : 24'h0);
                        set_cfg(dvs[i], lr[0], cf[0], ns[j],
                                (ns[j] == 32) ? 6'd0 : 6'(ns[j]), m);
                        launch_x(d, p);
                        finish_x(ns[j] == 8 || ns[j] == 2);
                    end
                end
            end
        end

        // R4 out-of-range count field means 32 bits
        set_cfg(1, 1'b1, 1'b1, 32, 6'd45, 24'h0F0F0F);
        launch_x(32'hC0FF_EE11, 32'h8765_4321);
        finish_x(1'b0);

        // R2 control persists: two starts from one control write
        set_cfg(0, 1'b0, 1'b1, 5, 6'd5, 24'h000100);
        launch_x(32'hA800_0000, 32'h0000_0013);
        finish_x(1'b0);
        launch_x(32'h5000_0000, 32'h0000_000C);
        finish_x(1'b0);

        // R11 control rewritten mid-transfer only affects the next transfer
        set_cfg(2, 1'b0, 1'b0, 8, 6'd8, 24'h000010);
        launch_x(32'h3C00_0000, 32'h0000_00C3);
        bus_wr(2'd1, ctrl_word(1'b1, 1'b0, 6'd16, 24'h400000));
        finish_x(1'b1);
        tb_lr = 1'b1; tb_n = 16; tb_mask = 24'h400000;
        launch_x(32'hDEAD_0000, 32'h0000_BEEF);
        finish_x(1'b1);

        // R9 / R10 busy status, ignored start, sticky overrun
        set_cfg(2, 1'b1, 1'b0, 8, 6'd8, 24'h000020);
        launch_x(32'h9600_0000, 32'h0000_0069);
        bus_rd(2'd1, rd);
        chk(rd == 32'h8000_0000, "R9", "status while busy", rd, 32'h8000_0000);
        bus_wr(2'd2, 32'hFFFF_FFFF);
        bus_rd(2'd1, rd);
        chk(rd == 32'h8000_0001, "R10", "overrun set while busy", rd, 32'h8000_0001);
        finish_x(1'b0);
        bus_rd(2'd1, rd);
        chk(rd == 32'h0000_0001, "R10", "overrun sticky after done", rd, 32'h0000_0001);
        repeat (40) @(negedge clk);
        chk(ss_n == '1 && sclk == 1'b0, "R10", "ignored start launched nothing",
            {7'h0, sclk, ss_n}, 32'h00FF_FFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule